// File: doc/BRIEF.md
# Serial Receiver with Idle-Timeout FIFO

This block is the receive half of a three-wire serial port. It turns a serial bit stream on one data pin into bytes, either as asynchronous frames timed by a 16x oversampling tick or as clocked 8-bit words sampled on a selectable edge of an external serial clock. Bit order is programmable in both modes. Completed bytes land in a small store. With buffering off, the store acts as a single holding register behind the shift register. With buffering on, it acts as a 16-entry first-in first-out queue.

The host pops the oldest byte with a read strobe and clears the sticky error flags with a status strobe. It can inspect the fill level, both pointers and any stored entry at any time without changing anything. Two interrupts are produced, each with its own enable. One reports that the store is full. The other reports that queued data has been waiting, with the queue not full, for more than four byte times since the last stored byte.

Top module: `rxs_top`

## Requirements
- R1: In asynchronous mode (cfg_sync_i=0) a frame is a low start bit, then 8 data bits (cfg_seven_i=0) or 7 data bits (cfg_seven_i=1), then a high stop bit, each bit 16 ticks long and sampled at mid-bit; a 7-bit byte is delivered with bit 7 cleared.
- R2: With cfg_lsb_first_i=1 the first received data bit becomes bit 0; with 0 the first received data bit becomes the top data bit (bit 7, or bit 6 for 7-bit frames).
- R3: In synchronous mode (cfg_sync_i=1) exactly 8 bits are taken from rxd_i, one per rising edge of sclk_i when cfg_sclk_inv_i=0 or per falling edge when cfg_sclk_inv_i=1.
- R4: A low stop bit sets frame_err_o and the byte is still stored; a pulse on stat_rd_i clears frame_err_o and overrun_o.
- R5: With cfg_fifo_en_i=0 the store holds one byte: fill_o becomes 1 after a byte arrives and the store counts as full until the byte is read.
- R6: With cfg_fifo_en_i=1 up to 16 bytes are kept and returned on rd_data_o in arrival order; the store counts as full only at 16 entries.
- R7: A byte completed while the store is full is discarded, leaves fill level, pointers and contents unchanged, and sets overrun_o until the next status read.
- R8: With the queue enabled, non-empty and not full, 640 ticks (four 10-bit byte times) without a stored byte set the timeout flag; every stored byte restarts the count; the flag clears when the queue is read empty.
- R9: wr_ptr_o, rd_ptr_o and fill_o report the queue state, and peek_data_o returns the entry at peek_idx_i, without affecting any other output.
- R10: irq_full_o equals irq_full_en_i AND full, and irq_tmo_o equals irq_tmo_en_i AND the timeout flag, both registered.
- R11: After reset the fill level, pointers, error flags and interrupts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rxd_i | input | 1 | Serial receive data |
| sclk_i | input | 1 | Serial clock for synchronous mode |
| cfg_sync_i | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfg_seven_i | input | 1 | 1 = 7 data bits in asynchronous mode |
| cfg_lsb_first_i | input | 1 | 1 = least significant bit first |
| cfg_sclk_inv_i | input | 1 | 1 = sample on falling serial-clock edge |
| cfg_fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| irq_full_en_i | input | 1 | Enable for the full interrupt |
| irq_tmo_en_i | input | 1 | Enable for the timeout interrupt |
| data_rd_i | input | 1 | Pop the oldest byte |
| stat_rd_i | input | 1 | Status read, clears sticky error flags |
| peek_idx_i | input | 4 | Entry index to inspect |
| rd_data_o | output | 8 | Oldest stored byte |
| peek_data_o | output | 8 | Contents of entry peek_idx_i |
| fill_o | output | 5 | Number of stored bytes |
| wr_ptr_o | output | 4 | Write pointer |
| rd_ptr_o | output | 4 | Read pointer |
| frame_err_o | output | 1 | Sticky framing error |
| overrun_o | output | 1 | Sticky overrun |
| irq_full_o | output | 1 | Full interrupt |
| irq_tmo_o | output | 1 | Idle-timeout interrupt |

## Verification
A wrong shift register or bit counter shows at rd_data_o two or three clocks after the last bit of the affected byte: a bit is misplaced, or bit 7 is set in a 7-bit frame. A corrupted pointer or fill count shows at once on wr_ptr_o, rd_ptr_o and fill_o, and at the latest on the next pop, as a byte returned out of order. A wrong idle counter only shows at irq_tmo_o, about 640 ticks after the last stored byte. For that reason the bench samples that output on both sides of the threshold, and also after a restart that would already have expired without it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef struct packed {
    logic       vld;
    logic [7:0] data;
    logic       ferr;
  } rx_byte_t;

  typedef enum logic [2:0] {
    AS_IDLE,
    AS_START,
    AS_DATA,
    AS_STOP,
    AS_WAIT_HI
  } async_st_e;

endpackage

// File: rtl/rxs_async_deser.sv
module rxs_async_deser
  import rxs_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     rxd,
  input  logic     seven,
  input  logic     lsb_first,
  output rx_byte_t byte_o
);

  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  logic            rxd_s1, rxd_s2;
  async_st_e       state;
  logic [TW-1:0]   tcnt;
  logic [3:0]      bcnt;
  logic [7:0]      sh;
  logic [3:0]      last_bit;

  assign last_bit = seven ? 4'd6 : 4'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_s1 <= 1'b1;
      rxd_s2 <= 1'b1;
    end else begin
      rxd_s1 <= rxd;
      rxd_s2 <= rxd_s1;
    end
  end

  always_ff @(posedge clk) begin
    byte_o.vld <= 1'b0;
    if (rst || !en) begin
      state       <= AS_IDLE;
      tcnt        <= '0;
      bcnt        <= '0;
      sh          <= '0;
      byte_o.data <= '0;
      byte_o.ferr <= 1'b0;
    end else if (tick) begin
      case (state)
        AS_IDLE: begin
          if (!rxd_s2) begin
            state <= AS_START;
            tcnt  <= '0;
          end
        end
        AS_START: begin
          if (tcnt == MID) begin
            tcnt <= '0;
            bcnt <= '0;
            sh   <= '0;
            state <= rxd_s2 ? AS_IDLE : AS_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        AS_DATA: begin
          if (tcnt == LAST) begin
            tcnt <= '0;
            sh   <= lsb_first ? {rxd_s2, sh[7:1]} : {sh[6:0], rxd_s2};
            bcnt <= bcnt + 1'b1;
            if (bcnt == last_bit) state <= AS_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        AS_STOP: begin
          if (tcnt == LAST) begin
            tcnt        <= '0;
            byte_o.vld  <= 1'b1;
            byte_o.data <= (lsb_first && seven) ? {1'b0, sh[7:1]} : sh;
            byte_o.ferr <= !rxd_s2;
            state       <= rxd_s2 ? AS_IDLE : AS_WAIT_HI;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        AS_WAIT_HI: begin
          if (rxd_s2) state <= AS_IDLE;
        end
        default: state <= AS_IDLE;
      endcase
    end
  end

  AST_BYTE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    byte_o.vld |-> $past(state) == AS_STOP) else $error("byte emitted outside stop bit"); // R1
  AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bcnt <= 4'd8) else $error("data bit counter out of range"); // R1

endmodule

// File: rtl/rxs_sync_deser.sv
module rxs_sync_deser
  import rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     sclk,
  input  logic     sclk_inv,
  input  logic     sd,
  input  logic     lsb_first,
  output rx_byte_t byte_o
);

  logic       sclk_s1, sclk_s2, sd_s1, sd_s2;
  logic       e_q, edge_w;
  logic [2:0] bcnt;
  logic [7:0] sh, sh_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s1 <= 1'b0;
      sclk_s2 <= 1'b0;
      sd_s1   <= 1'b1;
      sd_s2   <= 1'b1;
      e_q     <= 1'b0;
    end else begin
      sclk_s1 <= sclk;
      sclk_s2 <= sclk_s1;
      sd_s1   <= sd;
      sd_s2   <= sd_s1;
      e_q     <= sclk_s2 ^ sclk_inv;
    end
  end

  assign edge_w  = (sclk_s2 ^ sclk_inv) && !e_q;
  assign sh_next = lsb_first ? {sd_s2, sh[7:1]} : {sh[6:0], sd_s2};

  always_ff @(posedge clk) begin
    byte_o.vld  <= 1'b0;
    byte_o.ferr <= 1'b0;
    if (rst || !en) begin
      bcnt        <= '0;
      sh          <= '0;
      byte_o.data <= '0;
    end else if (edge_w) begin
      sh   <= sh_next;
      bcnt <= bcnt + 1'b1;
      if (bcnt == 3'd7) begin
        byte_o.vld  <= 1'b1;
        byte_o.data <= sh_next;
      end
    end
  end

  AST_SYNC_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    byte_o.vld |-> $past(edge_w)) else $error("sync byte without clock edge"); // R3

endmodule

// File: rtl/rxs_store.sv
module rxs_store #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  input  logic [AW-1:0] peek_idx,
  output logic [7:0]    head_q,
  output logic [7:0]    peek_q,
  output logic [AW:0]   count,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          accept
);

  localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];
  logic       pop_ok;

  assign full   = fifo_en ? (count == CNT_MAX) : (count != '0);
  assign accept = push && !full;
  assign pop_ok = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
    head_q <= mem[rd_ptr];
    peek_q <= mem[peek_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({accept, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX) else $error("fill count above depth"); // R6
  AST_DROP_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(wr_ptr) && $stable(count)) else $error("write while full"); // R7
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
    AW'(wr_ptr - rd_ptr) == count[AW-1:0]) else $error("pointer gap disagrees with count"); // R9

endmodule

// File: rtl/rxs_idle_timer.sv
module rxs_idle_timer #(
  parameter int LIMIT = 640,
  parameter int TCW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic fifo_en,
  input  logic nonempty,
  input  logic full,
  output logic tmo_flag
);

  localparam logic [TCW-1:0] LIM = TCW'(LIMIT);

  logic [TCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !nonempty) tmo_flag <= 1'b0;
    else if (fifo_en && !full && cnt == LIM) tmo_flag <= 1'b1;
  end

  AST_TMO_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !nonempty |=> !tmo_flag) else $error("timeout flag with empty queue"); // R8
  AST_TMO_WAITS: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> $past(cnt) == LIM) else $error("timeout before idle limit"); // R8

endmodule

// File: rtl/rxs_top.sv
module rxs_top
  import rxs_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 10,
  parameter int TMO_BYTES  = 4,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          sclk_i,
  input  logic          cfg_sync_i,
  input  logic          cfg_seven_i,
  input  logic          cfg_lsb_first_i,
  input  logic          cfg_sclk_inv_i,
  input  logic          cfg_fifo_en_i,
  input  logic          irq_full_en_i,
  input  logic          irq_tmo_en_i,
  input  logic          data_rd_i,
  input  logic          stat_rd_i,
  input  logic [AW-1:0] peek_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    peek_data_o,
  output logic [AW:0]   fill_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          frame_err_o,
  output logic          overrun_o,
  output logic          irq_full_o,
  output logic          irq_tmo_o
);

  localparam int TMO_LIMIT = OVS * FRAME_BITS * TMO_BYTES;

  rx_byte_t a_byte, s_byte, in_byte;
  logic     st_full, st_accept, tmo_flag;

  rxs_async_deser #(.OVS(OVS)) u_async (
    .clk       (clk),
    .rst       (rst),
    .en        (!cfg_sync_i),
    .tick      (tick_i),
    .rxd       (rxd_i),
    .seven     (cfg_seven_i),
    .lsb_first (cfg_lsb_first_i),
    .byte_o    (a_byte)
  );

  rxs_sync_deser u_sync (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_sync_i),
    .sclk      (sclk_i),
    .sclk_inv  (cfg_sclk_inv_i),
    .sd        (rxd_i),
    .lsb_first (cfg_lsb_first_i),
    .byte_o    (s_byte)
  );

  assign in_byte = cfg_sync_i ? s_byte : a_byte;

  rxs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (cfg_fifo_en_i),
    .push      (in_byte.vld),
    .push_data (in_byte.data),
    .pop       (data_rd_i),
    .peek_idx  (peek_idx_i),
    .head_q    (rd_data_o),
    .peek_q    (peek_data_o),
    .count     (fill_o),
    .wr_ptr    (wr_ptr_o),
    .rd_ptr    (rd_ptr_o),
    .full      (st_full),
    .accept    (st_accept)
  );

  rxs_idle_timer #(.LIMIT(TMO_LIMIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .restart  (st_accept),
    .fifo_en  (cfg_fifo_en_i),
    .nonempty (fill_o != '0),
    .full     (st_full),
    .tmo_flag (tmo_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun_o   <= 1'b0;
      frame_err_o <= 1'b0;
      irq_full_o  <= 1'b0;
      irq_tmo_o   <= 1'b0;
    end else begin
      if (in_byte.vld && st_full) overrun_o <= 1'b1;
      else if (stat_rd_i)         overrun_o <= 1'b0;
      if (in_byte.vld && in_byte.ferr) frame_err_o <= 1'b1;
      else if (stat_rd_i)              frame_err_o <= 1'b0;
      irq_full_o <= irq_full_en_i && st_full;
      irq_tmo_o  <= irq_tmo_en_i && tmo_flag;
    end
  end

  AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
    !irq_full_en_i |=> !irq_full_o) else $error("full irq while disabled"); // R10
  AST_TMO_MASK: assert property (@(posedge clk) disable iff (rst)
    !irq_tmo_en_i |=> !irq_tmo_o) else $error("timeout irq while disabled"); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !stat_rd_i) |=> overrun_o) else $error("overrun dropped without status read"); // R7

endmodule

// File: tb/rxs_top_tb.sv
module rxs_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       sclk_i = 1'b0;
  logic       cfg_sync_i = 1'b0, cfg_seven_i = 1'b0, cfg_lsb_first_i = 1'b1;
  logic       cfg_sclk_inv_i = 1'b0, cfg_fifo_en_i = 1'b0;
  logic       irq_full_en_i = 1'b0, irq_tmo_en_i = 1'b0;
  logic       data_rd_i = 1'b0, stat_rd_i = 1'b0;
  logic [3:0] peek_idx_i = '0;
  logic [7:0] rd_data_o, peek_data_o;
  logic [4:0] fill_o;
  logic [3:0] wr_ptr_o, rd_ptr_o;
  logic       frame_err_o, overrun_o, irq_full_o, irq_tmo_o;

  int errors = 0;
  int checks = 0;
  int exp_wr = 0;
  int exp_rd = 0;

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_i = ~tick_i;
  end

  rxs_top u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rxd_i(rxd_i), .sclk_i(sclk_i),
    .cfg_sync_i(cfg_sync_i), .cfg_seven_i(cfg_seven_i), .cfg_lsb_first_i(cfg_lsb_first_i),
    .cfg_sclk_inv_i(cfg_sclk_inv_i), .cfg_fifo_en_i(cfg_fifo_en_i),
    .irq_full_en_i(irq_full_en_i), .irq_tmo_en_i(irq_tmo_en_i),
    .data_rd_i(data_rd_i), .stat_rd_i(stat_rd_i), .peek_idx_i(peek_idx_i),
    .rd_data_o(rd_data_o), .peek_data_o(peek_data_o), .fill_o(fill_o),
    .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o), .frame_err_o(frame_err_o),
    .overrun_o(overrun_o), .irq_full_o(irq_full_o), .irq_tmo_o(irq_tmo_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] v, input bit seven, input bit lsb, input bit stop_val);
    int n;
    n = seven ? 7 : 8;
    @(negedge clk);
    rxd_i = 1'b0;
    wait_clk(32);
    for (int k = 0; k < n; k++) begin
      rxd_i = v[lsb ? k : n - 1 - k];
      wait_clk(32);
    end
    rxd_i = stop_val;
    wait_clk(32);
    rxd_i = 1'b1;
    wait_clk(12);
  endtask

  task automatic send_sync(input logic [7:0] v, input bit lsb, input bit inv);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rxd_i = v[lsb ? k : 7 - k];
      wait_clk(4);
      sclk_i = ~inv;
      wait_clk(4);
      sclk_i = inv;
    end
    wait_clk(6);
    rxd_i = 1'b1;
  endtask

  task automatic set_sync(input bit lsb, input bit inv);
    @(negedge clk);
    cfg_sync_i = 1'b0;
    cfg_lsb_first_i = lsb;
    cfg_sclk_inv_i = inv;
    sclk_i = inv;
    wait_clk(5);
    cfg_sync_i = 1'b1;
    wait_clk(2);
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    wait_clk(3);
    check(req, rd_data_o, exp);
    data_rd_i = 1'b1;
    @(negedge clk);
    data_rd_i = 1'b0;
    exp_rd = (exp_rd + 1) % 16;
    wait_clk(3);
  endtask

  task automatic stat_pulse();
    @(negedge clk);
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(3);
    // R11 reset state
    check("R11 fill", fill_o, 0);
    check("R11 wr_ptr", wr_ptr_o, 0);
    check("R11 rd_ptr", rd_ptr_o, 0);
    check("R11 flags", {frame_err_o, overrun_o, irq_full_o, irq_tmo_o}, 0);

    // R1 R2 asynchronous frames, 7 and 8 bits, both orders
    for (int i = 0; i < 24; i++) begin
      logic [7:0] v;
      bit seven, lsb;
      v = 8'((i * 37 + 11) & 8'hFF);
      seven = i[0];
      lsb = i[1];
      cfg_sync_i = 1'b0;
      cfg_seven_i = seven;
      cfg_lsb_first_i = lsb;
      send_async(v, seven, lsb, 1'b1);
      exp_wr = (exp_wr + 1) % 16;
      check("R5 fill after byte", fill_o, 1);
      pop_check(lsb ? "R1 R2 async lsb-first" : "R1 R2 async msb-first",
                seven ? (v & 8'h7F) : v);
    end
    check("R1 no framing error", frame_err_o, 0);

    // R3 R2 synchronous sweep over every byte value and both edges/orders
    for (int v = 0; v < 256; v++) begin
      bit lsb, inv;
      lsb = v[2];
      inv = v[3];
      set_sync(lsb, inv);
      send_sync(8'(v), lsb, inv);
      exp_wr = (exp_wr + 1) % 16;
      pop_check("R3 R2 sync byte", 8'(v));
    end
    check("R9 wr_ptr after sweep", wr_ptr_o, exp_wr);
    check("R9 rd_ptr after sweep", rd_ptr_o, exp_rd);

    // R4 framing error: low stop bit, byte kept
    set_sync(1'b1, 1'b0);
    cfg_sync_i = 1'b0;
    cfg_seven_i = 1'b0;
    cfg_lsb_first_i = 1'b1;
    wait_clk(4);
    send_async(8'hA5, 1'b0, 1'b1, 1'b0);
    exp_wr = (exp_wr + 1) % 16;
    check("R4 frame_err set", frame_err_o, 1);
    check("R4 byte stored", fill_o, 1);
    stat_pulse();
    check("R4 frame_err cleared", frame_err_o, 0);
    pop_check("R4 stored data", 8'hA5);

    // R5 R7 holding register overrun
    irq_full_en_i = 1'b1;
    set_sync(1'b1, 1'b0);
    send_sync(8'h3C, 1'b1, 1'b0);
    exp_wr = (exp_wr + 1) % 16;
    wait_clk(3);
    check("R5 single entry full", fill_o, 1);
    check("R10 irq_full hold", irq_full_o, 1);
    send_sync(8'hC3, 1'b1, 1'b0);
    wait_clk(3);
    check("R7 overrun hold", overrun_o, 1);
    check("R7 fill unchanged", fill_o, 1);
    check("R7 wr_ptr unchanged", wr_ptr_o, exp_wr);
    stat_pulse();
    check("R4 overrun cleared", overrun_o, 0);
    pop_check("R7 first byte kept", 8'h3C);
    check("R10 irq_full released", irq_full_o, 0);

    // R8 idle timeout with restart
    cfg_fifo_en_i = 1'b1;
    irq_tmo_en_i = 1'b1;
    send_sync(8'h11, 1'b1, 1'b0);
    exp_wr = (exp_wr + 1) % 16;
    wait_clk(1000);
    check("R8 no timeout early", irq_tmo_o, 0);
    send_sync(8'h22, 1'b1, 1'b0);
    exp_wr = (exp_wr + 1) % 16;
    wait_clk(1000);
    check("R8 restart on store", irq_tmo_o, 0);
    wait_clk(500);
    check("R8 timeout raised", irq_tmo_o, 1);
    irq_tmo_en_i = 1'b0;
    wait_clk(3);
    check("R10 timeout masked", irq_tmo_o, 0);
    irq_tmo_en_i = 1'b1;
    wait_clk(3);
    check("R10 timeout unmasked", irq_tmo_o, 1);
    pop_check("R8 data 1", 8'h11);
    check("R8 flag held while data", irq_tmo_o, 1);
    pop_check("R8 data 2", 8'h22);
    wait_clk(3);
    check("R8 flag cleared on empty", irq_tmo_o, 0);

    // R6 R7 R9 queue fill, peek, overrun, drain
    for (int i = 0; i < 16; i++) begin
      send_sync(8'(i * 13 + 7), 1'b1, 1'b0);
      exp_wr = (exp_wr + 1) % 16;
    end
    wait_clk(3);
    check("R6 fill 16", fill_o, 16);
    check("R10 irq_full queue", irq_full_o, 1);
    check("R9 wr_ptr full", wr_ptr_o, exp_wr);
    check("R9 rd_ptr full", rd_ptr_o, exp_rd);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      peek_idx_i = 4'((exp_rd + i) % 16);
      wait_clk(2);
      check("R9 peek entry", peek_data_o, (i * 13 + 7) & 8'hFF);
    end
    check("R9 peek leaves fill", fill_o, 16);
    send_sync(8'hEE, 1'b1, 1'b0);
    wait_clk(3);
    check("R7 queue overrun", overrun_o, 1);
    check("R7 queue fill unchanged", fill_o, 16);
    peek_idx_i = 4'(exp_rd);
    wait_clk(3);
    check("R7 oldest entry kept", peek_data_o, 7);
    stat_pulse();
    for (int i = 0; i < 16; i++) begin
      pop_check("R6 queue order", 8'(i * 13 + 7));
      if (i == 0) check("R6 not full after pop", irq_full_o, 0);
    end
    check("R6 drained", fill_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule